// File: doc/BRIEF.md
# Hypervisor Interrupt CSR Aliasing Unit

This block keeps the interrupt-related control registers that a hart with hypervisor support needs for its virtual supervisor level. It stores the delegation mask, the hypervisor interrupt enables, the hypervisor-injected virtual pending bits, the guest external interrupt enables and the guest scratch word. From these it resolves the hypervisor pending view and the guest-visible enable and pending views. The guest views hold no storage of their own: each guest bit sits one position below its hypervisor counterpart and mirrors it only when the matching delegation bit is set.

A single CSR port (12-bit address, write data, write strobe) reaches every register. Reads are combinational in the same cycle. Writes take effect at the next rising clock edge. While the virtualization flag is high, the supervisor enable, pending and scratch addresses are steered to the guest views. The resolved pending vectors also leave the block as outputs for the trap logic next to it. The platform provides the guest external pending vector, the guest external source selector, a timer line and an external line aimed at the guest, and the supervisor counter-overflow pending bit.

Top module: `hvirq_csr_unit`

## Requirements
- R1: After reset, the delegation (0x603), hypervisor enable (0x604), guest external enable (0x607), virtual pending (0x645) and guest scratch (0x240) registers all read 0.
- R2: In the delegation register 0x603 only bits 13, 10, 6 and 2 hold written values. Every other bit, including 12, 9, 5 and 1, reads 0.
- R3: In the hypervisor enable register 0x604 only bits 12, 10, 6 and 2 are writable. In the virtual pending register 0x645 only bits 10, 6 and 2 are writable. All other bits of both read 0.
- R4: In the guest external enable register 0x607 only bits GEI_CNT down to 1 are writable. The guest external pending register 0xE12 reads the input vector with bit 0 and every bit above GEI_CNT forced to 0. Writes to 0xE12 and to the hypervisor pending register 0x608 have no effect.
- R5: Hypervisor pending bit 12 is 1 exactly when some bit i in 1..GEI_CNT is set in both the guest external pending input and the guest external enable register.
- R6: Hypervisor pending bit 10 is the OR of virtual pending bit 10, the external line, and the guest external pending bit selected by the selector input. A selector value of 0 or greater than GEI_CNT contributes 0.
- R7: The selected guest external term of pending bit 10 depends only on the pending input, and never on the guest external enable register.
- R8: Hypervisor pending bit 6 is virtual pending bit 6 OR the timer line, and bit 2 equals virtual pending bit 2. The pending output and a read of 0x608 carry only bits 12, 10, 6 and 2.
- R9: The guest enable view 0x204 shows hypervisor enable bits 2, 6 and 10 at bits 1, 5 and 9. Each view bit reads 0 and ignores writes when its delegation bit (2, 6, 10) is clear. When that delegation bit is set, a write goes through to the hypervisor enable bit.
- R10: The guest pending view 0x244 and the guest pending output show hypervisor pending bits 2, 6 and 10 at bits 1, 5 and 9, each gated by delegation bit 2, 6 or 10. Bit 13 shows the counter-overflow input gated by delegation bit 13. All other bits are 0.
- R11: A write to the guest pending view updates only virtual pending bit 2, from write data bit 1, and only while delegation bit 2 is set. Writes to view bits 5 and 9 have no effect.
- R12: The guest scratch register 0x240 stores and returns every bit of a written word.
- R13: While the virtualization flag is 1, addresses 0x104, 0x144 and 0x140 access 0x204, 0x244 and 0x240. While it is 0, those three addresses, like any unmapped address, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_we | input | 1 | CSR write strobe |
| virt_mode | input | 1 | Virtualization flag that steers supervisor addresses to guest views |
| csr_rdata | output | XLEN | Combinational CSR read data |
| gext_pend | input | XLEN | Guest external pending vector from the interrupt controller |
| guest_sel | input | SELW | Guest external source selector |
| vs_timer_line | input | 1 | Platform timer interrupt aimed at the guest |
| vs_ext_line | input | 1 | Other external interrupt aimed at the guest |
| ovf_pend | input | 1 | Supervisor counter-overflow pending bit |
| hyp_pend | output | XLEN | Resolved hypervisor pending vector |
| vs_pend | output | XLEN | Resolved guest pending vector |

## Verification
The bench builds the unit with XLEN 64, GEI_CNT 5 and a 6-bit selector. Selector values 6 and 7 and pending-vector bits 6 and above then fall outside the implemented range and can be driven, which exercises both the zero contribution and the masking of unimplemented bits. A behavioural model that knows only the requirements predicts the read data and both pending outputs on every cycle. The stimulus sweeps each delegation bit on and off around writes to the guest views, and toggles the platform lines against stored pending bits.

// File: rtl/hvirq_pkg.sv
package hvirq_pkg;

  // Native CSR addresses
  localparam logic [11:0] A_DELEG  = 12'h603;
  localparam logic [11:0] A_HEN    = 12'h604;
  localparam logic [11:0] A_GEN    = 12'h607;
  localparam logic [11:0] A_HPEND  = 12'h608;
  localparam logic [11:0] A_VPEND  = 12'h645;
  localparam logic [11:0] A_GPEND  = 12'hE12;
  localparam logic [11:0] A_VSEN   = 12'h204;
  localparam logic [11:0] A_VSPEND = 12'h244;
  localparam logic [11:0] A_VSSCR  = 12'h240;

  // Supervisor addresses steered to guest views while virtualized
  localparam logic [11:0] A_SEN    = 12'h104;
  localparam logic [11:0] A_SPEND  = 12'h144;
  localparam logic [11:0] A_SSCR   = 12'h140;

  // Hypervisor-side bit positions; guest views sit one position lower
  localparam int B_SW  = 2;
  localparam int B_TM  = 6;
  localparam int B_EX  = 10;
  localparam int B_GX  = 12;
  localparam int B_OVF = 13;

  localparam int N_VIEW = 3;
  localparam int VIEW_HV [N_VIEW] = '{B_SW, B_TM, B_EX};

  typedef struct packed {
    logic deleg;
    logic hen;
    logic gen;
    logic hpend;
    logic vpend;
    logic gpend;
    logic vsen;
    logic vspend;
    logic vsscr;
  } csr_sel_t;

endpackage

// File: rtl/hvirq_addr_map.sv
module hvirq_addr_map
  import hvirq_pkg::*;
(
  input  logic [11:0] addr,
  input  logic        virt,
  output csr_sel_t    sel
);

  logic [11:0] eff_addr;

  // Steer supervisor addresses onto guest views only while virtualized
  always_comb begin
    eff_addr = addr;
    if (virt) begin
      if (addr == A_SEN)   eff_addr = A_VSEN;
      if (addr == A_SPEND) eff_addr = A_VSPEND;
      if (addr == A_SSCR)  eff_addr = A_VSSCR;
    end
  end

  always_comb begin
    sel        = '0;
    sel.deleg  = (eff_addr == A_DELEG);
    sel.hen    = (eff_addr == A_HEN);
    sel.gen    = (eff_addr == A_GEN);
    sel.hpend  = (eff_addr == A_HPEND);
    sel.vpend  = (eff_addr == A_VPEND);
    sel.gpend  = (eff_addr == A_GPEND);
    sel.vsen   = (eff_addr == A_VSEN);
    sel.vspend = (eff_addr == A_VSPEND);
    sel.vsscr  = (eff_addr == A_VSSCR);
  end

endmodule

// File: rtl/hvirq_regs.sv
module hvirq_regs
  import hvirq_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int GEI_CNT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  input  logic            sel_deleg,
  input  logic            sel_hen,
  input  logic            sel_gen,
  input  logic            sel_vpend,
  input  logic            sel_vsen,
  input  logic            sel_vspend,
  input  logic            sel_vsscr,
  output logic [XLEN-1:0] deleg_q,
  output logic [XLEN-1:0] hen_q,
  output logic [XLEN-1:0] gen_q,
  output logic [XLEN-1:0] vpend_q,
  output logic [XLEN-1:0] scr_q
);

  localparam logic [XLEN-1:0] ONE         = XLEN'(1);
  localparam logic [XLEN-1:0] DELEG_WMASK = (ONE << B_SW) | (ONE << B_TM) | (ONE << B_EX) | (ONE << B_OVF);
  localparam logic [XLEN-1:0] HEN_WMASK   = (ONE << B_SW) | (ONE << B_TM) | (ONE << B_EX) | (ONE << B_GX);
  localparam logic [XLEN-1:0] VP_WMASK    = (ONE << B_SW) | (ONE << B_TM) | (ONE << B_EX);
  localparam logic [XLEN-1:0] GEN_WMASK   = ((ONE << (GEI_CNT + 1)) - ONE) & ~ONE;

  logic [XLEN-1:0] deleg_n, hen_n, gen_n, vpend_n, scr_n;
  logic            en_deleg, en_hen, en_gen, en_vpend, en_scr;

  // Clock enables per register
  assign en_deleg = wr_en & sel_deleg;
  assign en_hen   = wr_en & (sel_hen | sel_vsen);
  assign en_gen   = wr_en & sel_gen;
  assign en_vpend = wr_en & (sel_vpend | sel_vspend);
  assign en_scr   = wr_en & sel_vsscr;

  // Next-state values
  always_comb begin
    deleg_n = wdata & DELEG_WMASK;
    gen_n   = wdata & GEN_WMASK;
    scr_n   = wdata;

    hen_n = hen_q;
    if (sel_hen) begin
      hen_n = wdata & HEN_WMASK;
    end else begin
      for (int k = 0; k < N_VIEW; k++) begin
        if (deleg_q[VIEW_HV[k]]) hen_n[VIEW_HV[k]] = wdata[VIEW_HV[k]-1];
      end
    end

    vpend_n = vpend_q;
    if (sel_vpend) begin
      vpend_n = wdata & VP_WMASK;
    end else if (deleg_q[B_SW]) begin
      vpend_n[B_SW] = wdata[B_SW-1];
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deleg_q <= '0;
      hen_q   <= '0;
      gen_q   <= '0;
      vpend_q <= '0;
      scr_q   <= '0;
    end else begin
      if (en_deleg) deleg_q <= deleg_n;
      if (en_hen)   hen_q   <= hen_n;
      if (en_gen)   gen_q   <= gen_n;
      if (en_vpend) vpend_q <= vpend_n;
      if (en_scr)   scr_q   <= scr_n;
    end
  end

endmodule

// File: rtl/hvirq_pend_resolve.sv
module hvirq_pend_resolve
  import hvirq_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int GEI_CNT = 8,
  parameter int SELW    = 6
) (
  input  logic [XLEN-1:0] gext_pend,
  input  logic [SELW-1:0] guest_sel,
  input  logic            tmr_line,
  input  logic            ext_line,
  input  logic            ovf_pend,
  input  logic [XLEN-1:0] deleg_q,
  input  logic [XLEN-1:0] hen_q,
  input  logic [XLEN-1:0] gen_q,
  input  logic [XLEN-1:0] vpend_q,
  output logic [XLEN-1:0] hyp_pend,
  output logic [XLEN-1:0] vs_pend,
  output logic [XLEN-1:0] vs_en,
  output logic [XLEN-1:0] gpend_view
);

  localparam logic [XLEN-1:0] ONE       = XLEN'(1);
  localparam logic [XLEN-1:0] GEI_MASK  = ((ONE << (GEI_CNT + 1)) - ONE) & ~ONE;
  localparam logic [XLEN-1:0] VIEW_MASK = (ONE << B_SW) | (ONE << B_TM) | (ONE << B_EX);

  logic [GEI_CNT:0] sel_hit;
  logic             sel_term;
  logic             gx_any;

  assign gpend_view = gext_pend & GEI_MASK;

  // Selector match per implemented source; bit 0 never selects
  assign sel_hit[0] = 1'b0;
  for (genvar i = 1; i <= GEI_CNT; i++) begin : g_sel
    assign sel_hit[i] = (guest_sel == SELW'(i)) & gext_pend[i];
  end

  assign sel_term = |sel_hit;
  assign gx_any   = |(gpend_view & gen_q);

  always_comb begin
    hyp_pend       = vpend_q & VIEW_MASK;
    hyp_pend[B_TM] = vpend_q[B_TM] | tmr_line;
    hyp_pend[B_EX] = vpend_q[B_EX] | sel_term | ext_line;
    hyp_pend[B_GX] = gx_any;
  end

  always_comb begin
    vs_pend        = (hyp_pend & deleg_q & VIEW_MASK) >> 1;
    vs_pend[B_OVF] = deleg_q[B_OVF] & ovf_pend;
    vs_en          = (hen_q & deleg_q & VIEW_MASK) >> 1;
  end

endmodule

// File: rtl/hvirq_csr_unit.sv
module hvirq_csr_unit
  import hvirq_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int GEI_CNT = 8,
  parameter int SELW    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  input  logic            virt_mode,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [XLEN-1:0] gext_pend,
  input  logic [SELW-1:0] guest_sel,
  input  logic            vs_timer_line,
  input  logic            vs_ext_line,
  input  logic            ovf_pend,
  output logic [XLEN-1:0] hyp_pend,
  output logic [XLEN-1:0] vs_pend
);

  csr_sel_t        sel;
  logic [1:0]      rst_pipe;
  logic            rst_core_n;
  logic [XLEN-1:0] deleg_q, hen_q, gen_q, vpend_q, scr_q;
  logic [XLEN-1:0] vs_en, gpend_view;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  hvirq_addr_map u_map (
    .addr (csr_addr),
    .virt (virt_mode),
    .sel  (sel)
  );

  hvirq_regs #(.XLEN(XLEN), .GEI_CNT(GEI_CNT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (csr_we),
    .wdata      (csr_wdata),
    .sel_deleg  (sel.deleg),
    .sel_hen    (sel.hen),
    .sel_gen    (sel.gen),
    .sel_vpend  (sel.vpend),
    .sel_vsen   (sel.vsen),
    .sel_vspend (sel.vspend),
    .sel_vsscr  (sel.vsscr),
    .deleg_q    (deleg_q),
    .hen_q      (hen_q),
    .gen_q      (gen_q),
    .vpend_q    (vpend_q),
    .scr_q      (scr_q)
  );

  hvirq_pend_resolve #(.XLEN(XLEN), .GEI_CNT(GEI_CNT), .SELW(SELW)) u_pend (
    .gext_pend  (gext_pend),
    .guest_sel  (guest_sel),
    .tmr_line   (vs_timer_line),
    .ext_line   (vs_ext_line),
    .ovf_pend   (ovf_pend),
    .deleg_q    (deleg_q),
    .hen_q      (hen_q),
    .gen_q      (gen_q),
    .vpend_q    (vpend_q),
    .hyp_pend   (hyp_pend),
    .vs_pend    (vs_pend),
    .vs_en      (vs_en),
    .gpend_view (gpend_view)
  );

  // One-hot AND-OR read multiplexer
  always_comb begin
    csr_rdata = ({XLEN{sel.deleg}}  & deleg_q)
              | ({XLEN{sel.hen}}    & hen_q)
              | ({XLEN{sel.gen}}    & gen_q)
              | ({XLEN{sel.hpend}}  & hyp_pend)
              | ({XLEN{sel.vpend}}  & vpend_q)
              | ({XLEN{sel.gpend}}  & gpend_view)
              | ({XLEN{sel.vsen}}   & vs_en)
              | ({XLEN{sel.vspend}} & vs_pend)
              | ({XLEN{sel.vsscr}}  & scr_q);
  end

endmodule

// File: rtl/hvirq_csr_unit_chk.sv
module hvirq_csr_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [11:0]     csr_addr,
  input logic [XLEN-1:0] csr_wdata,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_rdata,
  input logic            vs_timer_line,
  input logic            vs_ext_line,
  input logic [XLEN-1:0] hyp_pend,
  input logic [XLEN-1:0] vs_pend
);

  localparam logic [XLEN-1:0] ONE      = XLEN'(1);
  localparam logic [XLEN-1:0] HP_MASK  = (ONE << 2) | (ONE << 6) | (ONE << 10) | (ONE << 12);
  localparam logic [XLEN-1:0] VSP_MASK = (ONE << 1) | (ONE << 5) | (ONE << 9) | (ONE << 13);

  assert_hip_layout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hyp_pend & ~HP_MASK) == '0);

  assert_vsip_layout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_pend & ~VSP_MASK) == '0);

  assert_vsip_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vs_pend[1] || hyp_pend[2]) && (!vs_pend[5] || hyp_pend[6]) && (!vs_pend[9] || hyp_pend[10]));

  assert_timer_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vs_timer_line |-> hyp_pend[6]);

  assert_ext_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vs_ext_line |-> hyp_pend[10]);

  assert_vpend_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'h645 && csr_wdata[2]) |=> hyp_pend[2]);

  assert_gen_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'h607 && csr_wdata == '0) |=> !hyp_pend[12]);

  assert_gpend_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'hE12) |-> !csr_rdata[0]);

endmodule

bind hvirq_csr_unit hvirq_csr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .csr_addr      (csr_addr),
  .csr_wdata     (csr_wdata),
  .csr_we        (csr_we),
  .csr_rdata     (csr_rdata),
  .vs_timer_line (vs_timer_line),
  .vs_ext_line   (vs_ext_line),
  .hyp_pend      (hyp_pend),
  .vs_pend       (vs_pend)
);

// File: tb/hvirq_csr_unit_bench.sv
`timescale 1ns/1ps
module hvirq_csr_unit_bench;

  localparam int W  = 64;
  localparam int G  = 5;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [11:0]   csr_addr;
  logic [W-1:0]  csr_wdata;
  logic          csr_we;
  logic          virt_mode;
  logic [W-1:0]  csr_rdata;
  logic [W-1:0]  gext_pend;
  logic [SW-1:0] guest_sel;
  logic          tmr_l, ext_l, ovf_l;
  logic [W-1:0]  hyp_pend, vs_pend;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Behavioural model state
  logic [W-1:0] m_dl, m_he, m_ge, m_vp, m_sc;

  always #10 clk = ~clk;

  hvirq_csr_unit #(.XLEN(W), .GEI_CNT(G), .SELW(SW)) u_hvirq_csr_unit (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .virt_mode(virt_mode), .csr_rdata(csr_rdata),
    .gext_pend(gext_pend), .guest_sel(guest_sel), .vs_timer_line(tmr_l),
    .vs_ext_line(ext_l), .ovf_pend(ovf_l), .hyp_pend(hyp_pend), .vs_pend(vs_pend)
  );

  function automatic logic [W-1:0] exp_hip();
    logic [W-1:0] r = '0;
    logic any = 1'b0;
    logic pick = 1'b0;
    for (int i = 1; i <= G; i++) begin
      if (gext_pend[i] && m_ge[i]) any = 1'b1;
      if (int'(guest_sel) == i && gext_pend[i]) pick = 1'b1;
    end
    r[12] = any;
    r[10] = m_vp[10] | pick | ext_l;
    r[6]  = m_vp[6] | tmr_l;
    r[2]  = m_vp[2];
    return r;
  endfunction

  function automatic logic [W-1:0] exp_vsp();
    logic [W-1:0] h = exp_hip();
    logic [W-1:0] r = '0;
    r[1]  = m_dl[2] & h[2];
    r[5]  = m_dl[6] & h[6];
    r[9]  = m_dl[10] & h[10];
    r[13] = m_dl[13] & ovf_l;
    return r;
  endfunction

  function automatic logic [W-1:0] exp_vse();
    logic [W-1:0] r = '0;
    r[1] = m_dl[2] & m_he[2];
    r[5] = m_dl[6] & m_he[6];
    r[9] = m_dl[10] & m_he[10];
    return r;
  endfunction

  function automatic logic [11:0] route(logic [11:0] a, logic v);
    if (v && a == 12'h104) return 12'h204;
    if (v && a == 12'h144) return 12'h244;
    if (v && a == 12'h140) return 12'h240;
    return a;
  endfunction

  function automatic logic [W-1:0] exp_read(logic [11:0] a, logic v);
    logic [W-1:0] gp = '0;
    for (int i = 1; i <= G; i++) gp[i] = gext_pend[i];
    case (route(a, v))
      12'h603: return m_dl;
      12'h604: return m_he;
      12'h607: return m_ge;
      12'h608: return exp_hip();
      12'h645: return m_vp;
      12'hE12: return gp;
      12'h204: return exp_vse();
      12'h244: return exp_vsp();
      12'h240: return m_sc;
      default: return '0;
    endcase
  endfunction

  task automatic apply_write(logic [11:0] a, logic v, logic [W-1:0] d);
    case (route(a, v))
      12'h603: begin m_dl = '0; m_dl[2] = d[2]; m_dl[6] = d[6]; m_dl[10] = d[10]; m_dl[13] = d[13]; end
      12'h604: begin m_he = '0; m_he[2] = d[2]; m_he[6] = d[6]; m_he[10] = d[10]; m_he[12] = d[12]; end
      12'h607: begin m_ge = '0; for (int i = 1; i <= G; i++) m_ge[i] = d[i]; end
      12'h645: begin m_vp = '0; m_vp[2] = d[2]; m_vp[6] = d[6]; m_vp[10] = d[10]; end
      12'h204: begin
        if (m_dl[2])  m_he[2]  = d[1];
        if (m_dl[6])  m_he[6]  = d[5];
        if (m_dl[10]) m_he[10] = d[9];
      end
      12'h244: if (m_dl[2]) m_vp[2] = d[1];
      12'h240: m_sc = d;
      default: ;
    endcase
  endtask

  task automatic chk(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // One cycle: drive, compare mid-cycle, then commit the model at the edge
  task automatic step(string tag, logic [11:0] a, logic [W-1:0] d, logic we, logic v);
    csr_addr = a; csr_wdata = d; csr_we = we; virt_mode = v;
    #5;
    chk(tag, "rdata", csr_rdata, exp_read(a, v));
    chk(tag, "hyp_pend", hyp_pend, exp_hip());
    chk(tag, "vs_pend", vs_pend, exp_vsp());
    @(posedge clk);
    if (we) apply_write(a, v, d);
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic wr(string tag, logic [11:0] a, logic [W-1:0] d, logic v = 1'b0);
    step(tag, a, d, 1'b1, v);
  endtask

  task automatic rd(string tag, logic [11:0] a, logic v = 1'b0);
    step(tag, a, '0, 1'b0, v);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_addr = '0; csr_wdata = '0; csr_we = 1'b0; virt_mode = 1'b0;
    gext_pend = '0; guest_sel = '0; tmr_l = 1'b0; ext_l = 1'b0; ovf_l = 1'b0;
    m_dl = '0; m_he = '0; m_ge = '0; m_vp = '0; m_sc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    rd("R1", 12'h603); rd("R1", 12'h604); rd("R1", 12'h607);
    rd("R1", 12'h645); rd("R1", 12'h240); rd("R1", 12'h608);

    // R2 delegation write mask
    wr("R2", 12'h603, '1); rd("R2", 12'h603);
    wr("R2", 12'h603, 64'h0000_0000_0000_1222); rd("R2", 12'h603);

    // R3 enable and virtual pending masks
    wr("R3", 12'h604, '1); rd("R3", 12'h604);
    wr("R3", 12'h645, '1); rd("R3", 12'h645); rd("R3", 12'h608);
    wr("R3", 12'h645, '0); rd("R3", 12'h608);
    wr("R3", 12'h604, 64'h0000_0000_0000_0440); rd("R3", 12'h604);

    // R4 guest external enable and pending masks, read-only registers
    wr("R4", 12'h607, '1); rd("R4", 12'h607);
    gext_pend = '1; rd("R4", 12'hE12);
    wr("R4", 12'hE12, '0); wr("R4", 12'h608, '1);
    rd("R4", 12'h608); rd("R4", 12'h645);

    // R5 guest external summary
    gext_pend = 64'h8; rd("R5", 12'h608);
    wr("R5", 12'h607, 64'h4); rd("R5", 12'h608);
    gext_pend = 64'h40; wr("R5", 12'h607, '1); rd("R5", 12'h608);
    gext_pend = 64'h1; rd("R5", 12'h608);
    gext_pend = 64'h20; rd("R5", 12'h608);
    wr("R5", 12'h607, '0); rd("R5", 12'h608);

    // R6 / R7 selected source, independent of the enable register
    gext_pend = 64'h10;
    for (int s = 0; s < 8; s++) begin guest_sel = SW'(s); rd("R6", 12'h608); end
    gext_pend = 64'hC0;
    for (int s = 5; s < 8; s++) begin guest_sel = SW'(s); rd("R6", 12'h608); end
    gext_pend = 64'h3E; guest_sel = 6'd3;
    wr("R7", 12'h607, '0); rd("R7", 12'h608);
    wr("R7", 12'h607, 64'h8); rd("R7", 12'h608);
    wr("R7", 12'h607, 64'h30); rd("R7", 12'h608);
    gext_pend = '0; rd("R7", 12'h608); guest_sel = '0;
    ext_l = 1'b1; rd("R6", 12'h608); ext_l = 1'b0;

    // R8 timer line and software bit
    tmr_l = 1'b1; rd("R8", 12'h608); tmr_l = 1'b0; rd("R8", 12'h608);
    wr("R8", 12'h645, 64'h4); rd("R8", 12'h608);
    wr("R8", 12'h645, 64'h440); tmr_l = 1'b1; rd("R8", 12'h608); tmr_l = 1'b0;

    // R9 guest enable view
    wr("R9", 12'h603, '0); wr("R9", 12'h604, '0);
    wr("R9", 12'h204, '1); rd("R9", 12'h604); rd("R9", 12'h204);
    wr("R9", 12'h603, 64'h44); wr("R9", 12'h204, '1);
    rd("R9", 12'h604); rd("R9", 12'h204);
    wr("R9", 12'h603, 64'h444); rd("R9", 12'h204);
    wr("R9", 12'h204, 64'h200); rd("R9", 12'h604);
    wr("R9", 12'h604, '1); wr("R9", 12'h603, 64'h400); rd("R9", 12'h204);

    // R10 guest pending view
    wr("R10", 12'h645, 64'h444); wr("R10", 12'h603, '0); rd("R10", 12'h244);
    wr("R10", 12'h603, 64'h4); rd("R10", 12'h244);
    wr("R10", 12'h603, 64'h2444); rd("R10", 12'h244);
    ovf_l = 1'b1; rd("R10", 12'h244);
    wr("R10", 12'h603, 64'h444); rd("R10", 12'h244); ovf_l = 1'b0;
    wr("R10", 12'h645, '0); tmr_l = 1'b1; rd("R10", 12'h244); tmr_l = 1'b0;

    // R11 guest pending view writes
    wr("R11", 12'h244, '1); rd("R11", 12'h645);
    wr("R11", 12'h244, '0); rd("R11", 12'h645);
    wr("R11", 12'h603, 64'h440); wr("R11", 12'h244, '1); rd("R11", 12'h645);

    // R12 scratch
    wr("R12", 12'h240, 64'hDEAD_BEEF_0123_4567); rd("R12", 12'h240);
    wr("R12", 12'h240, '1); rd("R12", 12'h240);

    // R13 address steering
    rd("R13", 12'h140); rd("R13", 12'h140, 1'b1);
    wr("R13", 12'h140, 64'h55AA, 1'b0); rd("R13", 12'h240);
    wr("R13", 12'h140, 64'h1234, 1'b1); rd("R13", 12'h240);
    wr("R13", 12'h603, 64'h2444);
    wr("R13", 12'h104, '0, 1'b1); rd("R13", 12'h604); rd("R13", 12'h104, 1'b1);
    wr("R13", 12'h104, '1, 1'b0); rd("R13", 12'h604); rd("R13", 12'h104);
    wr("R13", 12'h144, '1, 1'b1); rd("R13", 12'h144, 1'b1); rd("R13", 12'h144);
    rd("R13", 12'h123);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule